// File: doc/BRIEF.md
# Two-Wire Serial Slave with Write-Busy Polling

This block is the receive side of a two-wire serial slave. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and shifts in bytes on the rising edges of the bus clock. It answers each accepted byte with an acknowledge. A transaction has three parts: a slave address byte, then a command byte, then at most one data byte. The block hands the command and data bytes to the logic behind it and pulses a write strobe when the transaction closes.

The address byte carries a fixed 4-bit type code in its upper half and the device number in its lower half. The device number is set by four strap inputs. A command byte with its top bit set asks for a nonvolatile write. The stop that closes such a transaction starts an internal write period of programmable length. During that period the block refuses to acknowledge its own address. A bus master can therefore poll: it sends a start and the address, and it repeats this until the acknowledge returns.

Top module: `tws_slave`

## Requirements
- R1: After reset the data pull-down, the write strobe, the command byte output and the data byte output are all 0.
- R2: Until the first start condition, clock pulses and data bits on the bus produce no acknowledge and no write strobe.
- R3: A start condition is a falling data line while the clock is high. A start at any point, including partway through a byte, restarts reception with the address byte.
- R4: The address byte is accepted only when bits 7..4 equal 4'b0101, bits 3..0 equal the strap inputs, and no internal write is in progress. A rejected address gets no acknowledge, and the rest of that transaction is ignored until the next start.
- R5: Bits are sampled on rising bus-clock edges, most significant bit first. After an accepted address, the next byte is acknowledged and driven on the command output. The byte after that is acknowledged and driven on the data output.
- R6: Any further byte in the same transaction is not acknowledged, and it leaves both byte outputs unchanged.
- R7: An acknowledge pulls the data line low from the clock fall after the eighth bit until the clock fall after the ninth bit. The line is released before the master drives the next bit.
- R8: A stop condition (data rising while the clock is high) ends the transaction. If a command byte was accepted, the write strobe pulses high for exactly one system clock.
- R9: When the accepted command byte has bit 7 set, the stop starts an internal write of BUSY_CYCLES system clocks. During this write a matching address is not acknowledged.
- R10: Once the internal write has elapsed, a start followed by a matching address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| strap_addr | input | 4 | Device number straps, compared with address bits 3..0 |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| cmd_byte | output | 8 | Last accepted command byte |
| data_byte | output | 8 | Last accepted data byte |
| wr_strobe | output | 1 | One-cycle pulse at a stop that closes a transaction with a command |

## Verification
The assertions check several properties on every cycle. The pull-down only changes while the synchronized clock is low, or at a start or stop. The bit counter never passes eight. The write strobe lasts one cycle and always follows a stop. An address is never acknowledged while the write timer runs, and the timer counts down by one each cycle once loaded. Some behaviours are visible only at the pins over whole transactions, so only the bench scenarios can show them. These are the address comparison against random straps, the abort by a mid-byte start, the silence before the first start, the refused fourth byte, and the poll result changing from no acknowledge to acknowledge when the write period ends.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b0101;
    localparam int         BYTE_BITS = 8;
    localparam int         NV_BIT    = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_IGNORE
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_OVER
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] a, input logic [3:0] strap);
        return (a[7:4] == TYPE_CODE) && (a[3:0] == strap);
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_ADDR: return PH_CMD;
            PH_CMD:  return PH_DATA;
            default: return PH_OVER;
        endcase
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    // R3
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.stop));

endmodule

// File: rtl/tws_busy_timer.sv
module tws_busy_timer #(
    parameter int BUSY_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R9
    busy_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

    // R9
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load));

endmodule

// File: rtl/tws_byte_engine.sv
module tws_byte_engine
    import tws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [3:0] strap_addr,
    input  logic       busy,
    output logic       sda_pull_low,
    output logic [7:0] cmd_byte,
    output logic [7:0] data_byte,
    output logic       wr_strobe,
    output logic       nv_start
);
    eng_state_e state;
    phase_e     phase;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       got_cmd;
    logic       accept;

    always_comb begin
        case (phase)
            PH_ADDR: accept = addr_hit(shreg, strap_addr) && !busy;
            PH_CMD:  accept = 1'b1;
            PH_DATA: accept = 1'b1;
            default: accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            phase        <= PH_ADDR;
            bit_cnt      <= '0;
            shreg        <= '0;
            got_cmd      <= 1'b0;
            sda_pull_low <= 1'b0;
            cmd_byte     <= '0;
            data_byte    <= '0;
            wr_strobe    <= 1'b0;
            nv_start     <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            nv_start  <= 1'b0;
            if (evt.stop) begin
                state        <= ST_IDLE;
                sda_pull_low <= 1'b0;
                got_cmd      <= 1'b0;
                if (got_cmd) begin
                    wr_strobe <= 1'b1;
                    nv_start  <= cmd_byte[NV_BIT];
                end
            end else if (evt.start) begin
                state        <= ST_SHIFT;
                phase        <= PH_ADDR;
                bit_cnt      <= '0;
                sda_pull_low <= 1'b0;
            end else begin
                case (state)
                    ST_SHIFT: begin
                        if (evt.scl_rise && bit_cnt < 4'(BYTE_BITS)) begin
                            shreg   <= {shreg[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt.scl_fall && bit_cnt == 4'(BYTE_BITS)) begin
                            if (accept) begin
                                state        <= ST_ACK;
                                sda_pull_low <= 1'b1;
                                if (phase == PH_CMD) begin
                                    cmd_byte <= shreg;
                                    got_cmd  <= 1'b1;
                                end
                                if (phase == PH_DATA) begin
                                    data_byte <= shreg;
                                end
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull_low <= 1'b0;
                            state        <= ST_SHIFT;
                            bit_cnt      <= '0;
                            phase        <= next_phase(phase);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    pull_on_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_low) |-> (!$past(evt.scl) || $past(evt.start) || $past(evt.stop)));

    // R5
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= 4'(BYTE_BITS));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R8
    strobe_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(evt.stop));

    // R9
    no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && phase == PH_ADDR && $rose(sda_pull_low)) |-> !$past(busy));

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int BUSY_CYCLES = 500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [3:0] strap_addr,
    output logic       sda_pull_low,
    output logic [7:0] cmd_byte,
    output logic [7:0] data_byte,
    output logic       wr_strobe
);
    bus_evt_t evt;
    logic     busy;
    logic     nv_start;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    tws_byte_engine u_engine (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .strap_addr   (strap_addr),
        .busy         (busy),
        .sda_pull_low (sda_pull_low),
        .cmd_byte     (cmd_byte),
        .data_byte    (data_byte),
        .wr_strobe    (wr_strobe),
        .nv_start     (nv_start)
    );

    tws_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (nv_start),
        .busy (busy)
    );

endmodule

// File: tb/test_tws_slave.sv
module test_tws_slave;
    localparam int BUSY = 3000;
    localparam int Q    = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] strap = 4'h3;
    logic       sda_pull_low;
    logic [7:0] cmd_byte;
    logic [7:0] data_byte;
    logic       wr_strobe;
    wire        sda_bus = m_sda & ~sda_pull_low;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int pull_cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tws_slave #(.BUSY_CYCLES(BUSY)) i_tws_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (m_scl),
        .sda_in       (sda_bus),
        .strap_addr   (strap),
        .sda_pull_low (sda_pull_low),
        .cmd_byte     (cmd_byte),
        .data_byte    (data_byte),
        .wr_strobe    (wr_strobe)
    );

    always @(negedge clk) begin
        if (wr_strobe) strobes++;
        if (sda_pull_low) pull_cycles++;
    end

    function automatic logic ref_ack(input logic [7:0] a, input logic [3:0] s);
        return (a[7:4] == 4'b0101) && (a[3:0] == s);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wait_clk(Q);
        m_scl = 1'b1; wait_clk(2 * Q);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic released);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(Q);
        ack = ~sda_bus;
        wait_clk(Q);
        m_scl = 1'b0; wait_clk(Q);
        released = sda_bus;
    endtask

    // full write: address, command, data; returns the three ack bits
    task automatic write_txn(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                             output logic [2:0] acks);
        logic ak, rl;
        bus_start();
        send_byte(a, ak, rl); acks[2] = ak;
        send_byte(c, ak, rl); acks[1] = ak;
        send_byte(d, ak, rl); acks[0] = ak;
        bus_stop();
        wait_clk(4);
    endtask

    task automatic poll(input logic [7:0] a, output logic ack);
        logic rl;
        bus_start();
        send_byte(a, ack, rl);
        bus_stop();
        wait_clk(4);
    endtask

    initial begin
        logic       ak, rl;
        logic [2:0] acks;
        int         s0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        check(sda_pull_low == 1'b0, "R1 pull", sda_pull_low, 0);
        check(wr_strobe == 1'b0, "R1 strobe", wr_strobe, 0);
        check(cmd_byte == 8'h00 && data_byte == 8'h00, "R1 bytes", {cmd_byte, data_byte}, 0);

        // R2 traffic before any start
        m_scl = 1'b0; wait_clk(Q);
        for (int i = 7; i >= 0; i--) send_bit(i[0]);
        for (int i = 7; i >= 0; i--) send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        check(pull_cycles == 0, "R2 no ack before start", pull_cycles, 0);
        check(strobes == 0, "R2 no strobe before start", strobes, 0);

        // R5 R7 R8 basic write
        s0 = strobes;
        bus_start();
        send_byte({4'b0101, strap}, ak, rl);
        check(ak == 1'b1, "R5 address ack", ak, 1);
        check(rl == 1'b1, "R7 released after ack", rl, 1);
        send_byte(8'h2C, ak, rl);
        check(ak == 1'b1, "R5 command ack", ak, 1);
        send_byte(8'hA7, ak, rl);
        check(ak == 1'b1, "R5 data ack", ak, 1);
        // R6 extra byte refused
        send_byte(8'h55, ak, rl);
        check(ak == 1'b0, "R6 extra byte nack", ak, 0);
        bus_stop();
        wait_clk(4);
        check(cmd_byte == 8'h2C, "R5 cmd_byte", cmd_byte, 8'h2C);
        check(data_byte == 8'hA7, "R6 data_byte unchanged by extra", data_byte, 8'hA7);
        check(strobes == s0 + 1, "R8 one strobe", strobes - s0, 1);

        // R4 wrong type / wrong strap, no strobe
        s0 = strobes;
        write_txn({4'b0110, strap}, 8'h11, 8'h22, acks);
        check(acks == 3'b000, "R4 wrong type nack", acks, 0);
        write_txn({4'b0101, strap ^ 4'h8}, 8'h11, 8'h22, acks);
        check(acks == 3'b000, "R4 wrong strap nack", acks, 0);
        check(strobes == s0, "R4 no strobe on reject", strobes - s0, 0);
        check(cmd_byte == 8'h2C, "R4 cmd unchanged on reject", cmd_byte, 8'h2C);

        // R3 start partway through a byte aborts and restarts
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte({4'b0101, strap}, ak, rl);
        check(ak == 1'b1, "R3 restart address ack", ak, 1);
        send_byte(8'h3D, ak, rl);
        bus_stop();
        wait_clk(4);
        check(cmd_byte == 8'h3D, "R3 command after restart", cmd_byte, 8'h3D);

        // R4 R5 R8 random addresses and straps
        for (int n = 0; n < 20; n++) begin
            logic [7:0] a, c, d;
            logic       exp;
            logic [7:0] pc, pd;
            strap = 4'($urandom);
            a = ($urandom % 2) ? {4'b0101, strap} : 8'($urandom);
            c = {1'b0, 7'($urandom)};
            d = 8'($urandom);
            exp = ref_ack(a, strap);
            pc = cmd_byte; pd = data_byte;
            s0 = strobes;
            write_txn(a, c, d, acks);
            check(acks == {3{exp}}, "R4 random ack pattern", acks, {3{exp}});
            check(cmd_byte == (exp ? c : pc), "R5 random cmd", cmd_byte, exp ? c : pc);
            check(data_byte == (exp ? d : pd), "R5 random data", data_byte, exp ? d : pd);
            check(strobes == s0 + int'(exp), "R8 random strobe", strobes - s0, int'(exp));
        end

        // R9 R10 nonvolatile write then polling
        write_txn({4'b0101, strap}, 8'h81, 8'h40, acks);
        check(acks == 3'b111, "R9 nv write acked", acks, 7);
        poll({4'b0101, strap}, ak);
        check(ak == 1'b0, "R9 poll during busy nack", ak, 0);
        poll({4'b0101, strap}, ak);
        check(ak == 1'b0, "R9 second poll during busy nack", ak, 0);
        wait_clk(BUSY);
        poll({4'b0101, strap}, ak);
        check(ak == 1'b1, "R10 poll after busy ack", ak, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule